// File: doc/BRIEF.md
# SMBus Data-Phase Byte Counter with Packet Error Code

This block runs the data phase of an SMBus transfer for an I2C-style controller. It works either as a master transmitter or as a slave receiver. When a transfer starts it captures a programmed byte count, a PEC-enable flag, a reload flag, an automatic-end flag and an ACK/NACK choice. It then counts bytes across a byte-level handshake with the bus shifter. Bit-level shifting, arbitration and address matching are handled elsewhere. The block only sees whole bytes on valid/ready channels.

A CRC-8 (polynomial x^8+x^2+x+1, initial value 0) runs over every byte on the bus, starting with the address byte that is given at start. When PEC is on, the last byte of the last chunk is part of the count and is handled by the block:
- In master mode the block inserts that byte itself, and software is asked for one data byte fewer.
- In slave mode the block compares that byte against the CRC. A match is ACKed. A mismatch is NACKed and sets a sticky error.

With reload on, the block stops at the end of each chunk with the bus held and waits for software to supply a further count.

Back-pressure rules:
- A byte moves only when valid and ready are both high in the same cycle.
- Master mode: software ready (`sw_tready`) is the shifter's `tx_ready`, passed through while a software byte is wanted. The block never asks software for the PEC byte.
- Slave mode: `rx_ready` toward the shifter is `sw_rready` passed through, so a slow consumer stretches the bus clock.
- During a reload stall, and while idle, every ready and valid output is low.

Top module: `smb_pec_counter`

## Requirements
- R1: After reset `busy`, `chunk_hold`, `stop_req`, `cfg_err`, `pec_err`, `tx_valid`, `sw_tready`, `rx_ready` and `sw_rvalid` are all 0.
- R2: Configuration is captured only on a `go` pulse while idle, and on a `cont` pulse while in a reload stall. Changing `cfg_*` at any other time has no effect on the running transfer. A `go` pulse while busy is ignored.
- R3: In master mode (`cfg_mode`=0), software data handshakes (`sw_tvalid`&`sw_tready`) happen count-1 times when PEC is on and count times when it is off. A count of 1 with PEC on needs no software byte at all.
- R4: The master PEC byte is presented with `tx_pec`=1 and `sw_tready`=0. Its value is the CRC-8 (polynomial 0x07, initial value 0) over the address byte and every earlier data byte since `go`. The CRC is reset at each `go` and cleared to 0 after the PEC byte.
- R5: In master mode with automatic end on and reload off, `stop_req` pulses high for exactly one cycle, in the second cycle after the handshake of the final byte. At that point `busy` is already 0. Slave mode never raises `stop_req`.
- R6: In slave mode (`cfg_mode`=1), the last byte of the final chunk with PEC on is marked `sw_rpec`=1. Its `rx_ack` is 1 exactly when the byte equals the running CRC-8.
- R7: A mismatching slave PEC byte sets `pec_err`. It stays set until the next accepted `go`.
- R8: With reload on, when the count runs out `chunk_hold` rises. While it is high, `tx_valid`, `sw_tready`, `rx_ready` and `sw_rvalid` are 0. A `cont` pulse loads a new count, reload flag and ACK choice, and drops `chunk_hold`.
- R9: If reload is cleared at a `cont`, that chunk is final and, with PEC on, its last byte is the PEC byte. For example: count 1 with reload on, then `cont` with count 1 and reload on, then `cont` with count 1 and reload off gives two data bytes and a PEC byte.
- R10: Slave data bytes (not the PEC byte) get `rx_ack` = NOT of the captured `cfg_nack`.
- R11: A count of 0 with PEC on raises a one-cycle `cfg_err` and starts nothing. This applies at `go`, and at a `cont` that clears reload. A `cont` error also ends the transfer (`busy`=0).
- R12: A byte transfers only on valid&ready. `sw_tready` follows `tx_ready`, and `rx_ready` follows `sw_rready`, while a byte is wanted. All are 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | 0 master transmitter, 1 slave receiver |
| cfg_nbytes | input | CNT_W | Byte count of the next chunk, PEC included |
| cfg_pec_en | input | 1 | Last byte of the final chunk is the PEC |
| cfg_reload | input | 1 | Stall for more at the end of this chunk |
| cfg_autoend | input | 1 | Master: request STOP after the final byte |
| cfg_nack | input | 1 | Slave: NACK the data bytes of the chunk |
| go | input | 1 | Start (master) or address flag cleared (slave) |
| cont | input | 1 | New count written during a reload stall |
| addr_byte | input | 8 | Address byte that seeds the CRC |
| sw_tdata | input | 8 | Software transmit byte |
| sw_tvalid | input | 1 | Software transmit byte valid |
| sw_tready | output | 1 | Block accepts the software byte |
| tx_data | output | 8 | Byte to the bus shifter |
| tx_pec | output | 1 | Current `tx_data` is the PEC |
| tx_valid | output | 1 | `tx_data` valid |
| tx_ready | input | 1 | Shifter takes the byte |
| rx_data | input | 8 | Byte from the bus shifter |
| rx_valid | input | 1 | `rx_data` valid |
| rx_ready | output | 1 | Byte accepted; low stretches the clock |
| rx_ack | output | 1 | ACK (1) or NACK (0) for the accepted byte |
| sw_rdata | output | 8 | Received byte to software |
| sw_rpec | output | 1 | Received byte is the PEC |
| sw_rvalid | output | 1 | `sw_rdata` valid |
| sw_rready | input | 1 | Software takes the byte |
| busy | output | 1 | Transfer in progress |
| chunk_hold | output | 1 | Reload stall, bus held |
| stop_req | output | 1 | One-cycle STOP request |
| cfg_err | output | 1 | One-cycle configuration error |
| pec_err | output | 1 | Sticky slave PEC mismatch |

## Verification
The bench goes after several corner cases:
- A PEC-only transfer (count 1). A design that still asks software for a byte would get a software handshake and send the wrong value.
- A three-chunk slave reload whose last single-byte chunk must turn into the PEC check. A design that fixes the PEC position at `go` would ACK a corrupted byte, or treat a data byte as the PEC.
- A corrupted slave PEC. If the error were not sticky it would vanish before the next `go`.
- A configuration rewritten in mid-transfer. A design that is not latched would lengthen the transfer.
- Stalls while `rx_valid` is high. These catch a design that leaks `rx_ready` during a reload stall.
- Both configuration-error paths, at `go` and at `cont`.
- The exact stop cycle.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } smb_state_e;

  localparam logic [7:0] SMB_CRC_POLY = 8'h07;
endpackage

// File: rtl/smb_crc8.sv
module smb_crc8 #(
  parameter int         W    = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic [W-1:0] seed_byte,
  input  logic         upd,
  input  logic [W-1:0] upd_byte,
  input  logic         clr,
  output logic [W-1:0] crc
);
  logic [W-1:0] chain [0:W];
  logic [W-1:0] din;

  assign chain[0] = seed ? '0 : crc;
  assign din      = seed ? seed_byte : upd_byte;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb         = chain[i][W-1] ^ din[W-1-i];
    assign chain[i+1] = {chain[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc <= '0;
    else if (seed)      crc <= chain[W];
    else if (clr)       crc <= '0;
    else if (upd)       crc <= chain[W];
  end
endmodule

// File: rtl/smb_bytecnt.sv
module smb_bytecnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == W'(1));
endmodule

// File: rtl/smb_pec_counter.sv
module smb_pec_counter
  import smb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic [CNT_W-1:0] cfg_nbytes,
  input  logic             cfg_pec_en,
  input  logic             cfg_reload,
  input  logic             cfg_autoend,
  input  logic             cfg_nack,
  input  logic             go,
  input  logic             cont,
  input  logic [7:0]       addr_byte,
  input  logic [7:0]       sw_tdata,
  input  logic             sw_tvalid,
  output logic             sw_tready,
  output logic [7:0]       tx_data,
  output logic             tx_pec,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             rx_ack,
  output logic [7:0]       sw_rdata,
  output logic             sw_rpec,
  output logic             sw_rvalid,
  input  logic             sw_rready,
  output logic             busy,
  output logic             chunk_hold,
  output logic             stop_req,
  output logic             cfg_err,
  output logic             pec_err
);
  smb_state_e state_q;
  logic mode_q, pec_q, rel_q, auto_q, nack_q;
  logic cnt_zero, cnt_one;
  logic [7:0] crc;

  logic start_ok, start_bad, cont_ok, cont_bad;
  logic run_act, last_pec, hs, slave, master;

  assign start_ok  = (state_q == ST_IDLE) && go && !(cfg_pec_en && cfg_nbytes == '0);
  assign start_bad = (state_q == ST_IDLE) && go &&  (cfg_pec_en && cfg_nbytes == '0);
  assign cont_bad  = (state_q == ST_HOLD) && cont && pec_q && !cfg_reload && cfg_nbytes == '0;
  assign cont_ok   = (state_q == ST_HOLD) && cont && !cont_bad;

  assign run_act  = (state_q == ST_RUN) && !cnt_zero;
  assign last_pec = pec_q && !rel_q && cnt_one;
  assign slave    = run_act && mode_q;
  assign master   = run_act && !mode_q;

  // master transmit path
  assign tx_pec    = master && last_pec;
  assign tx_valid  = master && (last_pec || sw_tvalid);
  assign tx_data   = last_pec ? crc : sw_tdata;
  assign sw_tready = master && !last_pec && tx_ready;

  // slave receive path
  assign rx_ready  = slave && sw_rready;
  assign sw_rvalid = slave && rx_valid;
  assign sw_rdata  = rx_data;
  assign sw_rpec   = sw_rvalid && last_pec;
  assign rx_ack    = last_pec ? (rx_data == crc) : !nack_q;

  assign hs = mode_q ? (rx_valid && rx_ready) : (tx_valid && tx_ready);

  smb_crc8 #(.W(8), .POLY(SMB_CRC_POLY)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (start_ok),
    .seed_byte (addr_byte),
    .upd       (hs && !last_pec),
    .upd_byte  (mode_q ? rx_data : tx_data),
    .clr       (hs && last_pec),
    .crc       (crc)
  );

  smb_bytecnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok || cont_ok),
    .load_val (cfg_nbytes),
    .dec      (hs),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      pec_q    <= 1'b0;
      rel_q    <= 1'b0;
      auto_q   <= 1'b0;
      nack_q   <= 1'b0;
      stop_req <= 1'b0;
      cfg_err  <= 1'b0;
      pec_err  <= 1'b0;
    end else begin
      stop_req <= 1'b0;
      cfg_err  <= start_bad || cont_bad;
      if (mode_q && hs && last_pec && rx_data != crc) pec_err <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q <= ST_RUN;
          mode_q  <= cfg_mode;
          pec_q   <= cfg_pec_en;
          rel_q   <= cfg_reload;
          auto_q  <= cfg_autoend;
          nack_q  <= cfg_nack;
          pec_err <= 1'b0;
        end
        ST_RUN: if (cnt_zero) begin
          if (rel_q) state_q <= ST_HOLD;
          else begin
            state_q  <= ST_IDLE;
            stop_req <= !mode_q && auto_q;
          end
        end
        ST_HOLD: if (cont_bad) state_q <= ST_IDLE;
          else if (cont_ok) begin
            state_q <= ST_RUN;
            rel_q   <= cfg_reload;
            nack_q  <= cfg_nack;
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign chunk_hold = (state_q == ST_HOLD);
endmodule

// File: rtl/smb_pec_counter_chk.sv
module smb_pec_counter_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic busy,
  input logic chunk_hold,
  input logic tx_valid,
  input logic tx_pec,
  input logic sw_tready,
  input logic rx_ready,
  input logic sw_rvalid,
  input logic stop_req,
  input logic cfg_err,
  input logic pec_err
);
  a_r8_hold_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_hold |-> !tx_valid && !rx_ready && !sw_tready && !sw_rvalid);

  a_r4_pec_not_from_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_pec) |-> !sw_tready);

  a_r7_pec_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err && !(go && !busy)) |=> pec_err);

  a_r11_cfg_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  a_r5_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  a_r5_stop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !busy && !chunk_hold);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready && !sw_rvalid && !sw_tready);
endmodule

bind smb_pec_counter smb_pec_counter_chk u_chk (.*);

// File: tb/test_smb_pec_counter.sv
module test_smb_pec_counter;
  logic clk = 0, rst_n = 0;
  logic cfg_mode = 0, cfg_pec_en = 0, cfg_reload = 0, cfg_autoend = 0, cfg_nack = 0;
  logic [7:0] cfg_nbytes = 0, addr_byte = 0, sw_tdata = 0, rx_data = 0;
  logic go = 0, cont = 0, sw_tvalid = 0, tx_ready = 0, rx_valid = 0, sw_rready = 0;
  logic sw_tready, tx_pec, tx_valid, rx_ready, rx_ack, sw_rpec, sw_rvalid;
  logic busy, chunk_hold, stop_req, cfg_err, pec_err;
  logic [7:0] tx_data, sw_rdata;

  always #5 clk = ~clk;

  smb_pec_counter i_smb_pec_counter (.*);

  int n_chk = 0, n_err = 0, cyc = 0;
  bit src_on = 0, sink_on = 0, tx_hs_seen = 0, rx_hs_seen = 0;
  logic [7:0] tx_word = 8'h10;
  logic [7:0] rx_q[$];
  logic [7:0] bus_log[$];
  logic [7:0] ack_log[$];
  logic [7:0] rpec_log[$];
  int n_swtx = 0, n_stop = 0, n_cfgerr = 0;

  // reference model state
  bit m_busy = 0, m_tcr = 0, m_mode = 0, m_pec = 0, m_rel = 0, m_auto = 0, m_nack = 0;
  bit m_pecerr = 0, m_stop = 0, m_cfgerr = 0;
  int m_rem = 0, m_crc = 0;

  function automatic int crc8(int c, int d);
    for (int i = 7; i >= 0; i--) begin
      int fb;
      fb = ((c >> 7) ^ (d >> i)) & 1;
      c = (c << 1) & 255;
      if (fb != 0) c = c ^ 7;
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stimulus sources and sinks
  always @(posedge clk) begin
    #1;
    cyc++;
    if (tx_hs_seen) tx_word = tx_word + 8'h11;
    sw_tdata  = tx_word;
    sw_tvalid = src_on && (cyc % 3 != 1);
    tx_ready  = sink_on && (cyc % 4 != 2);
    if (rx_hs_seen && rx_q.size() > 0) void'(rx_q.pop_front());
    rx_valid  = (rx_q.size() > 0) && (cyc % 3 != 2);
    rx_data   = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
    sw_rready = sink_on && (cyc % 5 != 3);
  end

  // per-clock comparison and model step
  always @(negedge clk) begin : cmp
    bit run, lp, e_txv, e_swtr, e_rxr, e_swrv, e_ack, hs;
    int e_txd, b;
    if (rst_n) begin
      run    = m_busy && !m_tcr && m_rem > 0;
      lp     = m_pec && !m_rel && m_rem == 1;
      e_txv  = run && !m_mode && (lp || sw_tvalid);
      e_txd  = lp ? m_crc : int'(sw_tdata);
      e_swtr = run && !m_mode && !lp && tx_ready;
      e_rxr  = run && m_mode && sw_rready;
      e_swrv = run && m_mode && rx_valid;
      e_ack  = lp ? (int'(rx_data) == m_crc) : !m_nack;
      chk("R2", busy, m_busy, "busy");
      chk("R8", chunk_hold, m_tcr, "chunk_hold");
      chk("R7", pec_err, m_pecerr, "pec_err");
      chk("R5", stop_req, m_stop, "stop_req");
      chk("R11", cfg_err, m_cfgerr, "cfg_err");
      chk("R12", tx_valid, e_txv, "tx_valid");
      chk("R3", sw_tready, e_swtr, "sw_tready");
      chk("R12", rx_ready, e_rxr, "rx_ready");
      chk("R12", sw_rvalid, e_swrv, "sw_rvalid");
      if (e_txv) begin
        chk("R4", tx_data, e_txd, "tx_data");
        chk("R4", tx_pec, lp, "tx_pec");
      end
      if (e_swrv) begin
        chk("R6", sw_rpec, lp, "sw_rpec");
        chk("R10", rx_ack, e_ack, "rx_ack");
      end
      // logs from the ports
      tx_hs_seen = sw_tvalid && sw_tready;
      rx_hs_seen = rx_valid && rx_ready;
      if (tx_hs_seen) n_swtx++;
      if (tx_valid && tx_ready) bus_log.push_back(tx_data);
      if (rx_hs_seen) begin
        ack_log.push_back({7'd0, rx_ack});
        rpec_log.push_back({7'd0, sw_rpec});
      end
      if (stop_req) n_stop++;
      if (cfg_err) n_cfgerr++;
      // model step
      m_stop = 0;
      m_cfgerr = 0;
      if (!m_busy) begin
        if (go) begin
          if (cfg_pec_en && cfg_nbytes == 0) m_cfgerr = 1;
          else begin
            m_busy = 1; m_mode = cfg_mode; m_rem = cfg_nbytes; m_pec = cfg_pec_en;
            m_rel = cfg_reload; m_auto = cfg_autoend; m_nack = cfg_nack;
            m_crc = crc8(0, addr_byte); m_pecerr = 0;
          end
        end
      end else if (m_tcr) begin
        if (cont) begin
          if (m_pec && cfg_nbytes == 0 && !cfg_reload) begin
            m_cfgerr = 1; m_busy = 0; m_tcr = 0;
          end else begin
            m_rem = cfg_nbytes; m_rel = cfg_reload; m_nack = cfg_nack; m_tcr = 0;
          end
        end
      end else if (m_rem == 0) begin
        if (m_rel) m_tcr = 1;
        else begin
          m_busy = 0;
          m_stop = !m_mode && m_auto;
        end
      end else begin
        hs = m_mode ? (rx_valid && e_rxr) : (e_txv && tx_ready);
        if (hs) begin
          b = m_mode ? int'(rx_data) : e_txd;
          if (lp) begin
            if (m_mode && b != m_crc) m_pecerr = 1;
            m_crc = 0;
          end else m_crc = crc8(m_crc, b);
          m_rem--;
        end
      end
    end
  end

  task automatic pulse_go();
    @(posedge clk); #1 go = 1;
    @(posedge clk); #1 go = 0;
  endtask

  task automatic pulse_cont();
    @(posedge clk); #1 cont = 1;
    @(posedge clk); #1 cont = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_hold();
    for (int i = 0; i < 2000 && !chunk_hold; i++) @(negedge clk);
  endtask

  task automatic setup(input bit mode, input int n, input bit pec, input bit rel,
                       input bit aend, input bit nack, input logic [7:0] adr);
    @(posedge clk); #2;
    cfg_mode = mode; cfg_nbytes = n[7:0]; cfg_pec_en = pec; cfg_reload = rel;
    cfg_autoend = aend; cfg_nack = nack; addr_byte = adr;
    bus_log.delete(); ack_log.delete(); rpec_log.delete();
    n_swtx = 0; n_stop = 0; n_cfgerr = 0;
    src_on = 1; sink_on = 1;
  endtask

  function automatic int bus_pec();
    int c;
    c = crc8(0, addr_byte);
    for (int i = 0; i + 1 < bus_log.size(); i++) c = crc8(c, bus_log[i]);
    return c;
  endfunction

  initial begin : watchdog
    wait (cyc > 100000);
    n_err++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", busy, 0, "reset busy");
    chk("R1", chunk_hold | stop_req | cfg_err | pec_err, 0, "reset flags");
    chk("R1", tx_valid | sw_tready | rx_ready | sw_rvalid, 0, "reset handshakes");
    rst_n = 1;

    // master, PEC, count 3, automatic end; config rewritten mid-transfer (R2)
    setup(0, 3, 1, 0, 1, 0, 8'hA6);
    pulse_go();
    #1 cfg_nbytes = 8'd9; cfg_pec_en = 0;
    pulse_go();
    wait_idle();
    chk("R3", n_swtx, 2, "software bytes count 3 with PEC");
    chk("R2", bus_log.size(), 3, "bus bytes after cfg rewrite");
    chk("R4", bus_log[2], bus_pec(), "master PEC value");
    chk("R5", n_stop, 1, "stop pulses with autoend");

    // master, PEC only (count 1)
    setup(0, 1, 1, 0, 1, 0, 8'h3C);
    pulse_go();
    wait_idle();
    chk("R3", n_swtx, 0, "software bytes count 1 with PEC");
    chk("R4", bus_log.size() == 1 ? int'(bus_log[0]) : -1, crc8(0, 8'h3C), "PEC-only byte");

    // master, no PEC, count 2, no automatic end
    setup(0, 2, 0, 0, 0, 0, 8'h52);
    pulse_go();
    wait_idle();
    chk("R3", n_swtx, 2, "software bytes without PEC");
    chk("R5", n_stop, 0, "no stop without autoend");

    // slave, 2 data + correct PEC
    setup(1, 3, 1, 0, 1, 0, 8'hA7);
    c = crc8(crc8(crc8(0, 8'hA7), 8'h11), 8'h22);
    rx_q = '{8'h11, 8'h22, c[7:0]};
    pulse_go();
    wait_idle();
    chk("R6", ack_log.size() == 3 ? int'(ack_log[2]) : -1, 1, "good PEC ACKed");
    chk("R6", rpec_log.size() == 3 ? int'(rpec_log[2]) : -1, 1, "third byte flagged PEC");
    chk("R7", pec_err, 0, "no error on good PEC");
    chk("R5", n_stop, 0, "slave never requests stop");

    // slave, corrupted PEC: NACK and sticky error
    setup(1, 3, 1, 0, 0, 0, 8'hA7);
    rx_q = '{8'h11, 8'h22, c[7:0] ^ 8'h01};
    pulse_go();
    wait_idle();
    chk("R6", ack_log.size() == 3 ? int'(ack_log[2]) : -1, 0, "bad PEC NACKed");
    repeat (5) @(negedge clk);
    chk("R7", pec_err, 1, "error stays after transfer");

    // slave reload, three single-byte chunks, last turns into PEC (R9)
    setup(1, 1, 1, 1, 0, 0, 8'h21);
    c = crc8(crc8(crc8(0, 8'h21), 8'h5A), 8'hC3);
    rx_q = '{8'h5A, 8'hC3, c[7:0]};
    pulse_go();
    @(negedge clk);
    chk("R7", pec_err, 0, "error cleared by go");
    wait_hold();
    repeat (6) @(negedge clk);
    chk("R8", chunk_hold & !rx_ready, 1, "held with data waiting");
    chk("R8", ack_log.size(), 1, "one byte before first reload");
    pulse_cont();
    wait_hold();
    #1 cfg_reload = 0;
    pulse_cont();
    wait_idle();
    chk("R9", ack_log.size(), 3, "bytes over three chunks");
    chk("R9", rpec_log.size() == 3 ? int'(rpec_log[2]) : -1, 1, "last chunk byte is PEC");
    chk("R9", ack_log.size() == 3 ? int'(ack_log[2]) : -1, 1, "reload PEC ACKed");

    // slave NACK choice on data bytes
    setup(1, 2, 0, 0, 0, 1, 8'h44);
    rx_q = '{8'h01, 8'h02};
    pulse_go();
    wait_idle();
    chk("R10", ack_log.size() == 2 ? int'(ack_log[0] | ack_log[1]) : -1, 0, "data bytes NACKed");

    // configuration error at go
    setup(0, 0, 1, 0, 1, 0, 8'h10);
    pulse_go();
    repeat (4) @(negedge clk);
    chk("R11", n_cfgerr, 1, "cfg error at go");
    chk("R11", busy, 0, "no transfer after cfg error");

    // master reload with PEC: 2 then 2 (1 data + PEC)
    setup(0, 2, 1, 1, 1, 0, 8'h6E);
    pulse_go();
    wait_hold();
    chk("R8", n_swtx, 2, "full first chunk from software");
    #1 cfg_reload = 0;
    pulse_cont();
    wait_idle();
    chk("R9", n_swtx, 3, "software bytes over reload");
    chk("R4", bus_log.size() == 4 ? int'(bus_log[3]) : -1, bus_pec(), "PEC after reload");

    // configuration error at cont
    setup(0, 1, 1, 1, 1, 0, 8'h0F);
    pulse_go();
    wait_hold();
    #1 cfg_nbytes = 0; cfg_reload = 0;
    pulse_cont();
    repeat (4) @(negedge clk);
    chk("R11", n_cfgerr, 1, "cfg error at cont");
    chk("R11", busy, 0, "transfer ended by cont error");

    src_on = 0; sink_on = 0;
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule